// File: doc/BRIEF.md
# DMA Transfer Mode Selector

This block picks the fastest DMA transfer mode that a storage device and its host controller both support. The result never exceeds a mode that the caller requests. The caller presents the device's identify capability words, the host's per-class mode masks, the cable type, the device kind and a requested mode code. It then pulses `start`. One cycle later `done` pulses, and the selected mode code appears on `mode_out`. A code of zero means that no DMA mode is usable.

In the same evaluation the block flags identify data whose DMA words contradict each other. A second operation, chosen with `step_down`, gives the recovery mode to use after CRC errors: the next slower ultra mode, or PIO mode 4. All inputs must be held stable from the cycle `start` is high until `done` is seen.

Top module: `dma_mode_pick`

## Requirements
- R1: While `rst_n` is low and after its release, `mode_out` is 0x00 and `done` and `id_bad` are 0 until the first `start`.
- R2: `done` is high in exactly the cycle after each cycle in which `start` is high. `mode_out` and `id_bad` change only in that cycle and hold their value otherwise.
- R3: The mode classes are searched in priority order: ultra (base 0x40), then multiword (base 0x20), then single-word (base 0x10). A class is skipped when `req_mode` is below its base. The first class with a non-empty mask wins.
- R4: A class mask is the AND of the host mask and the low byte of the device word. The mode found is the class base plus the index of the highest set bit of that mask.
- R5: The ultra class is empty unless `field_valid[2]` is 1. The multiword class is empty unless `field_valid[1]` is 1. When `field_valid[1]` is 1, the single-word mask is `sword_word[7:0] & host_sword_mask`.
- R6: When `req_mode` is above 0x42 and `cable_80w` is 0, any of bits 3 to 7 in the ultra mask are cleared, leaving bits 0 to 2.
- R7: When `field_valid[1]` is 0, the single-word mask comes from `legacy_sw_timing`. For a value t with 1 <= t <= 2 it is `((2<<t)-1) & host_sword_mask`. For t equal to 0 or above 2 it is empty.
- R8: The selected mode is the smaller of the mode found and `req_mode`. If no class yields a mode, the result is 0x00.
- R9: When `is_disk` is 0 and `host_no_pkt_dma` is 1, the selected mode is 0x00.
- R10: `id_bad` is 1 in two cases. With `field_valid[2]` set, it is 1 when both `ultra_word[15:8]` and `mword_word[15:8]` are nonzero. With `field_valid[2]` clear and `field_valid[1]` set, it is 1 when both `mword_word[15:8]` and `sword_word[15:8]` are nonzero. Otherwise it is 0.
- R11: With `step_down` high at `start`, a `req_mode` in 0x41..0x47 yields `req_mode`-1. Any other value yields 0x0C (PIO mode 4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one evaluation |
| step_down | input | 1 | 1: CRC recovery step instead of selection |
| req_mode | input | 8 | Requested mode code (current mode for step-down) |
| field_valid | input | 3 | Identify field-valid flags |
| ultra_word | input | 16 | Ultra DMA word: low byte supported, high byte active |
| mword_word | input | 16 | Multiword DMA word |
| sword_word | input | 16 | Single-word DMA word |
| legacy_sw_timing | input | 8 | Legacy single-word timing mode number |
| host_ultra_mask | input | 8 | Host-supported ultra modes |
| host_mword_mask | input | 8 | Host-supported multiword modes |
| host_sword_mask | input | 8 | Host-supported single-word modes |
| cable_80w | input | 1 | 80-wire cable detected |
| is_disk | input | 1 | Device is a disk (0: packet device) |
| host_no_pkt_dma | input | 1 | Host forbids DMA for packet devices |
| mode_out | output | 8 | Selected mode code |
| done | output | 1 | Result valid pulse |
| id_bad | output | 1 | Identify DMA words inconsistent |

## Verification
Some properties hold on every cycle, and the assertions check those. The `done` pulse follows `start` by one cycle, and outputs stay still between evaluations. A selection never exceeds the request and always lands inside one class. Packet devices behind a no-packet-DMA host get zero. A slow cable never yields an ultra mode above 2. Step-down gives either one ultra mode less or PIO mode 4. Other results depend on the exact input encoding, and only the bench scenarios show them. These are the class priority and skipping, the highest-bit pick, the legacy timing conversion, the cable reduction applying only above ultra 2, and the two inconsistency cases. The bench compares them against its own model on every clock.

// File: rtl/dma_mode_pick.sv
module dma_mode_pick #(
  parameter int MW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          step_down,
  input  logic [7:0]    req_mode,
  input  logic [2:0]    field_valid,
  input  logic [15:0]   ultra_word,
  input  logic [15:0]   mword_word,
  input  logic [15:0]   sword_word,
  input  logic [7:0]    legacy_sw_timing,
  input  logic [MW-1:0] host_ultra_mask,
  input  logic [MW-1:0] host_mword_mask,
  input  logic [MW-1:0] host_sword_mask,
  input  logic          cable_80w,
  input  logic          is_disk,
  input  logic          host_no_pkt_dma,
  output logic [7:0]    mode_out,
  output logic          done,
  output logic          id_bad
);
  localparam logic [7:0] UBASE = 8'h40;
  localparam logic [7:0] MBASE = 8'h20;
  localparam logic [7:0] SBASE = 8'h10;
  localparam logic [7:0] PIO4  = 8'h0C;
  localparam logic [7:0] UTOP  = UBASE + 8'(MW - 1);

  function automatic logic [7:0] top_bit(input logic [MW-1:0] m);
    top_bit = 8'd0;
    for (int i = 0; i < MW; i++)
      if (m[i]) top_bit = 8'(i);
  endfunction

  logic [MW-1:0] u_raw, u_msk, m_msk, s_leg, s_msk;
  logic          u_slow;
  logic [7:0]    found, capped, pick, next_mode;
  logic          bad_now;

  assign u_raw  = field_valid[2] ? (host_ultra_mask & ultra_word[MW-1:0]) : '0;
  assign u_slow = (req_mode > UBASE + 8'd2) && !cable_80w && (|u_raw[MW-1:3]);
  assign u_msk  = u_slow ? (u_raw & MW'(7)) : u_raw;
  assign m_msk  = field_valid[1] ? (host_mword_mask & mword_word[MW-1:0]) : '0;
  assign s_leg  = (legacy_sw_timing != 8'd0 && legacy_sw_timing <= 8'd2)
                ? ((MW'(2) << legacy_sw_timing[1:0]) - MW'(1)) : '0;
  assign s_msk  = field_valid[1] ? (host_sword_mask & sword_word[MW-1:0])
                                 : (host_sword_mask & s_leg);

  always_comb begin
    if (req_mode >= UBASE && u_msk != '0)      found = UBASE + top_bit(u_msk);
    else if (req_mode >= MBASE && m_msk != '0) found = MBASE + top_bit(m_msk);
    else if (req_mode >= SBASE && s_msk != '0) found = SBASE + top_bit(s_msk);
    else                                       found = 8'd0;
  end

  assign capped    = (found < req_mode) ? found : req_mode;
  assign pick      = (!is_disk && host_no_pkt_dma) ? 8'd0 : capped;
  assign next_mode = (req_mode > UBASE && req_mode <= UTOP) ? req_mode - 8'd1 : PIO4;

  always_comb begin
    if (field_valid[2])      bad_now = (ultra_word[15:8] != 8'd0) && (mword_word[15:8] != 8'd0);
    else if (field_valid[1]) bad_now = (mword_word[15:8] != 8'd0) && (sword_word[15:8] != 8'd0);
    else                     bad_now = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_out <= 8'd0;
      done     <= 1'b0;
      id_bad   <= 1'b0;
    end else begin
      done <= start;
      if (start) begin
        mode_out <= step_down ? next_mode : pick;
        id_bad   <= bad_now;
      end
    end
  end
endmodule

// File: rtl/dma_mode_pick_chk.sv
module dma_mode_pick_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       step_down,
  input logic [7:0] req_mode,
  input logic       cable_80w,
  input logic       is_disk,
  input logic       host_no_pkt_dma,
  input logic [7:0] mode_out,
  input logic       done,
  input logic       id_bad
);
  assert_done_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);
  assert_done_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done && $stable(mode_out) && $stable(id_bad));
  assert_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start && !step_down |=> mode_out <= $past(req_mode));
  assert_one_class_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start && !step_down |=> mode_out == 8'd0 ||
      (mode_out[7] == 1'b0 && mode_out[3] == 1'b0 && $countones(mode_out[6:4]) == 1));
  assert_pkt_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start && !step_down && !is_disk && host_no_pkt_dma |=> mode_out == 8'd0);
  assert_slow_cable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start && !step_down && !cable_80w |=> !(mode_out >= 8'h43 && mode_out <= 8'h47));
  assert_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
    start && step_down |=> mode_out == 8'h0C ||
      (mode_out[7:3] == 5'b01000 && mode_out == $past(req_mode) - 8'd1));
  assert_reset_R1: assert property (@(posedge clk)
    !rst_n |=> mode_out == 8'd0 && !done && !id_bad);
endmodule

bind dma_mode_pick dma_mode_pick_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .step_down(step_down),
  .req_mode(req_mode), .cable_80w(cable_80w), .is_disk(is_disk),
  .host_no_pkt_dma(host_no_pkt_dma), .mode_out(mode_out), .done(done),
  .id_bad(id_bad)
);

// File: tb/sim_dma_mode_pick.sv
module sim_dma_mode_pick;
  logic clk = 0, rst_n = 0, start = 0, step_down = 0;
  logic [7:0] req_mode = 0, legacy_sw_timing = 0;
  logic [2:0] field_valid = 0;
  logic [15:0] ultra_word = 0, mword_word = 0, sword_word = 0;
  logic [7:0] host_ultra_mask = 0, host_mword_mask = 0, host_sword_mask = 0;
  logic cable_80w = 0, is_disk = 1, host_no_pkt_dma = 0;
  logic [7:0] mode_out;
  logic done, id_bad;
  int checks = 0, fails = 0, cyc = 0;
  logic finished = 0;

  always #4 clk = ~clk;

  dma_mode_pick u0 (.*);

  function automatic int hi_idx(int m);
    int r = -1;
    for (int b = 7; b >= 0; b--) if (r < 0 && ((m >> b) & 1)) r = b;
    return r;
  endfunction

  function automatic int model_pick();
    int base[3] = '{64, 32, 16};
    int msk[3];
    int req = req_mode, res = 0, t = legacy_sw_timing;
    if (step_down) return (req > 64 && req <= 71) ? req - 1 : 12;
    if (!is_disk && host_no_pkt_dma) return 0;
    msk[0] = field_valid[2] ? (host_ultra_mask & ultra_word[7:0]) : 0;
    if (req > 66 && !cable_80w && (msk[0] & 'hF8) != 0) msk[0] = msk[0] & 7;
    msk[1] = field_valid[1] ? (host_mword_mask & mword_word[7:0]) : 0;
    if (field_valid[1]) msk[2] = host_sword_mask & sword_word[7:0];
    else if (t >= 1 && t <= 2) msk[2] = ((2 << t) - 1) & host_sword_mask;
    else msk[2] = 0;
    for (int c = 0; c < 3; c++)
      if (res == 0 && req >= base[c] && msk[c] != 0) res = base[c] + hi_idx(msk[c]);
    return (res < req) ? res : req;
  endfunction

  function automatic bit model_bad();
    if (field_valid[2]) return ultra_word[15:8] != 0 && mword_word[15:8] != 0;
    if (field_valid[1]) return mword_word[15:8] != 0 && sword_word[15:8] != 0;
    return 0;
  endfunction

  int  m_mode = 0;
  bit  m_done = 0, m_bad = 0;
  always @(posedge clk) begin
    if (!rst_n) begin m_mode <= 0; m_done <= 0; m_bad <= 0; end
    else begin
      m_done <= start;
      if (start) begin m_mode <= model_pick(); m_bad <= model_bad(); end
    end
  end

  always @(negedge clk) if (!finished) begin
    checks++;
    if (int'(mode_out) != m_mode || done != m_done || id_bad != m_bad) begin
      fails++;
      $display("FAIL R2/R4 per-cycle: mode=%h done=%b bad=%b expected mode=%h done=%b bad=%b",
               mode_out, done, id_bad, m_mode[7:0], m_done, m_bad);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 50000 && !finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(string tag, logic [7:0] em, bit eb);
    checks++;
    if (mode_out !== em || id_bad !== eb) begin
      fails++;
      $display("FAIL %s: mode=%h bad=%b expected mode=%h bad=%b", tag, mode_out, id_bad, em, eb);
    end
  endtask

  task automatic run(logic [7:0] req, string tag, logic [7:0] em, bit eb = 0);
    req_mode = req; start = 1;
    @(negedge clk); start = 0;
    checks++;
    if (done !== 1'b1) begin fails++; $display("FAIL R2: done=%b expected 1", done); end
    chk(tag, em, eb);
    @(negedge clk);
    checks++;
    if (done !== 1'b0) begin fails++; $display("FAIL R2: done=%b expected 0", done); end
    chk({tag, " hold"}, em, eb);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 in reset", 8'h00, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after reset", 8'h00, 0);
    field_valid = 3'b110; ultra_word = 16'h007F; host_ultra_mask = 8'h7F;
    mword_word = 16'h0007; host_mword_mask = 8'h07; sword_word = 16'h0007;
    host_sword_mask = 8'h07; cable_80w = 1;
    run(8'h46, "R4 full ultra", 8'h46);
    run(8'h45, "R8 capped by request", 8'h45);
    cable_80w = 0;
    run(8'h46, "R6 slow cable", 8'h42);
    run(8'h42, "R6 request at ultra 2", 8'h42);
    host_ultra_mask = 8'h05;
    run(8'h46, "R4 host mask highest bit", 8'h42);
    run(8'h22, "R3 ultra skipped", 8'h22);
    host_mword_mask = 8'h03;
    run(8'h27, "R3 multiword highest", 8'h21);
    run(8'h13, "R3 single-word", 8'h12);
    run(8'h0F, "R8 below all classes", 8'h00);
    field_valid = 3'b010; host_ultra_mask = 8'h7F;
    run(8'h46, "R5 ultra invalid", 8'h21);
    field_valid = 3'b000; host_sword_mask = 8'h07; legacy_sw_timing = 8'd2;
    run(8'h46, "R7 legacy mode 2", 8'h12);
    legacy_sw_timing = 8'd1; host_sword_mask = 8'h01;
    run(8'h46, "R7 legacy masked by host", 8'h10);
    legacy_sw_timing = 8'd3; host_sword_mask = 8'h07;
    run(8'h46, "R7 legacy out of range", 8'h00);
    legacy_sw_timing = 8'd0;
    run(8'h46, "R7 legacy zero", 8'h00);
    field_valid = 3'b110; cable_80w = 1; is_disk = 0; host_no_pkt_dma = 1;
    run(8'h46, "R9 packet device", 8'h00);
    host_no_pkt_dma = 0;
    run(8'h46, "R9 packet device allowed", 8'h46);
    is_disk = 1;
    ultra_word = 16'h047F; mword_word = 16'h0207;
    run(8'h46, "R10 ultra and multiword active", 8'h46, 1);
    ultra_word = 16'h007F; sword_word = 16'h0107;
    run(8'h46, "R10 bit2 ignores single-word", 8'h46, 0);
    field_valid = 3'b010;
    run(8'h22, "R10 multiword and single-word active", 8'h21, 1);
    step_down = 1;
    run(8'h45, "R11 step ultra", 8'h44, 1);
    run(8'h40, "R11 ultra 0 to PIO", 8'h0C, 1);
    run(8'h22, "R11 multiword to PIO", 8'h0C, 1);
    step_down = 0;
    repeat (2) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule